// File: doc/BRIEF.md
# Cycle-Stealing Record Readout Handshake

Once an acquisition has frozen its circular sample memory, this block hands the stored record to a host processor. Each transfer moves one word and has its own request/acknowledge handshake. An end-of-record strobe starts the readout at once. The block raises its request, waits for the acknowledge, and puts one 16-bit word on the host bus while the acknowledge is high. Each word holds the channel 1 byte and the channel 2 byte together. The word is complete when the acknowledge is released. The read address then steps by one, and the next request waits for a slow pacing tick.

The first word comes from the address where acquisition stopped. That address holds the oldest sample, so the record leaves in time order and the address wraps through the top of the memory to zero. Software sets the word count when the record ends. When that many words have moved, the request stays low and a done flag rises. An active-low clear returns the block to idle for the next acquisition. The acquisition-side output enable is high only in idle, so the sample bus is free during readout.

States: `ST_IDLE`, `ST_REQ`, `ST_HELD`, `ST_PACE`, `ST_DONE`. Transitions:
- IDLE→REQ on end-of-record.
- REQ→HELD on acknowledge high.
- HELD→PACE on acknowledge low when words remain.
- HELD→DONE on acknowledge low after the last word.
- PACE→REQ on a pacing tick.
- Any state→IDLE when the clear is low at a clock edge.
- DONE holds until that clear.

Top module: `rec_readout_dma`

## Requirements
- R1: After power-on reset the block is idle: `dma_req`=0, `done`=0, `acq_oe`=1, `bus_oe`=0, `rd_addr`=0.
- R2: While idle, `rd_addr` is reloaded from `stop_addr` on every clock. An `eor` high at a clock edge in idle captures `stop_addr` and `xfer_len`, and `dma_req` is 1 from that edge on.
- R3: `acq_oe` is 1 exactly while the block is idle. It is 0 from the edge that accepts `eor` until the clear.
- R4: `bus_oe` equals `dma_ack` while a request is open or the acknowledge is being held (states REQ and HELD). In every other state `bus_oe` is 0 whatever `dma_ack` does.
- R5: `data_out` is {`ch1_byte`, `ch2_byte`} (channel 1 in bits 15:8, channel 2 in bits 7:0) while `bus_oe` is 1, and 0 otherwise.
- R6: `dma_req` falls at the first edge where `dma_ack` is seen high. The word completes at the first later edge with `dma_ack` low. At that edge `rd_addr` increments by one, wrapping from 4095 to 0.
- R7: After a word that is not the last, `dma_req` rises again at the first edge where the free-running pacing tick is high. The tick is high for one clock in every `PACE_DIV` clocks, starting with clock `PACE_DIV` after reset.
- R8: After `xfer_len` completed words (1 to 4096), `done` is 1 and `dma_req` stays 0 until the clear.
- R9: `clr_n` low at a clock edge returns the block to idle from any state, including mid-handshake. `done` goes to 0 and `acq_oe` to 1.
- R10: `eor` outside idle is ignored, and in DONE it changes neither `done` nor `dma_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| clr_n | input | 1 | Synchronous active-low return to idle |
| eor | input | 1 | End-of-record strobe from acquisition |
| stop_addr | input | AW | Address where acquisition froze (oldest sample) |
| xfer_len | input | AW+1 | Number of words to transfer, 1 to 2^AW |
| dma_ack | input | 1 | Host acknowledge |
| ch1_byte | input | BW | Channel 1 sample read at `rd_addr` |
| ch2_byte | input | BW | Channel 2 sample read at `rd_addr` |
| dma_req | output | 1 | Host transfer request |
| bus_oe | output | 1 | Output enable of the host-side data latch |
| acq_oe | output | 1 | Acquisition-side output enable |
| done | output | 1 | Programmed word count has been moved |
| rd_addr | output | AW | Sample memory read address |
| data_out | output | 2*BW | Packed word toward the host bus |

## Verification
The hardest cases to reach from the ports are a record that crosses the top of the address space, and a clear that arrives while the acknowledge is still held. The bench reaches the first by placing the stop address a few words below 4095 and asking for more words than remain above it. It reaches the second by pulsing the clear after two words, at a moment when its acknowledge responder is holding the line high. That leaves a stale acknowledge in idle. Acknowledge delays and hold times vary between records, so the pacing tick falls at different offsets from the end of each word.

// File: rtl/rrd_pkg.sv
package rrd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_REQ  = 3'd1,
        ST_HELD = 3'd2,
        ST_PACE = 3'd3,
        ST_DONE = 3'd4
    } rrd_state_t;

endpackage

// File: rtl/rrd_pacer.sv
module rrd_pacer #(
    parameter int DIV = 40
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    // DIV must be at least 2
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = (cnt_q == LAST);

    // R7: the tick lasts one clock only
    a_r7_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/rrd_addr_ctr.sv
module rrd_addr_ctr #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          capture,
    input  logic          step,
    input  logic [AW-1:0] stop_addr,
    input  logic [AW:0]   xfer_len,
    output logic [AW-1:0] rd_addr,
    output logic          last_word
);
    logic [AW-1:0] addr_q;
    logic [AW:0]   cnt_q;
    logic [AW:0]   len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            cnt_q  <= '0;
            len_q  <= '0;
        end else begin
            if (load) begin
                addr_q <= stop_addr;
                cnt_q  <= '0;
            end else if (step) begin
                addr_q <= addr_q + 1'b1;
                cnt_q  <= cnt_q + 1'b1;
            end
            if (capture) begin
                len_q <= xfer_len;
            end
        end
    end

    assign rd_addr   = addr_q;
    assign last_word = (cnt_q == len_q - 1'b1);

    // R2: the accepting edge freezes the stop address as the first read address
    a_r2_first_addr: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> rd_addr == $past(stop_addr));

    // R6: a completed word advances the address by exactly one, modulo the depth
    a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> rd_addr == AW'($past(rd_addr) + 1'b1));

endmodule

// File: rtl/rrd_fsm.sv
module rrd_fsm
    import rrd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr_n,
    input  logic eor,
    input  logic dma_ack,
    input  logic tick,
    input  logic last_word,
    output logic dma_req,
    output logic acq_oe,
    output logic done,
    output logic fetch_win,
    output logic load,
    output logic capture,
    output logic step
);
    rrd_state_t state_q;
    rrd_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (!clr_n) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (eor)      state_d = ST_REQ;
                ST_REQ:  if (dma_ack)  state_d = ST_HELD;
                ST_HELD: if (!dma_ack) state_d = last_word ? ST_DONE : ST_PACE;
                ST_PACE: if (tick)     state_d = ST_REQ;
                ST_DONE:               state_d = ST_DONE;
                default:               state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        dma_req   = 1'b0;
        acq_oe    = 1'b0;
        done      = 1'b0;
        fetch_win = 1'b0;
        load      = 1'b0;
        capture   = 1'b0;
        step      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                acq_oe  = 1'b1;
                load    = 1'b1;
                capture = eor;
            end
            ST_REQ: begin
                dma_req   = 1'b1;
                fetch_win = 1'b1;
            end
            ST_HELD: begin
                fetch_win = 1'b1;
                step      = !dma_ack && clr_n;
            end
            ST_PACE: ;
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    // R6: an acknowledged request is withdrawn on the next edge
    a_r6_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && dma_ack) |=> !dma_req);

    // R3: the sample bus is never driven while the host is being asked
    a_r3_bus_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(acq_oe && dma_req));

    // R8: a finished readout stays finished and silent until cleared
    a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done && clr_n) |=> (done && !dma_req));

    // R9: the clear always lands in idle
    a_r9_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> (acq_oe && !done && !dma_req));

endmodule

// File: rtl/rec_readout_dma.sv
module rec_readout_dma #(
    parameter int AW       = 12,
    parameter int BW       = 8,
    parameter int PACE_DIV = 40
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_n,
    input  logic            eor,
    input  logic [AW-1:0]   stop_addr,
    input  logic [AW:0]     xfer_len,
    input  logic            dma_ack,
    input  logic [BW-1:0]   ch1_byte,
    input  logic [BW-1:0]   ch2_byte,
    output logic            dma_req,
    output logic            bus_oe,
    output logic            acq_oe,
    output logic            done,
    output logic [AW-1:0]   rd_addr,
    output logic [2*BW-1:0] data_out
);
    localparam int WW = 2 * BW;

    logic tick;
    logic last_word;
    logic fetch_win;
    logic load;
    logic capture;
    logic step;

    rrd_pacer #(.DIV(PACE_DIV)) u_pacer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    rrd_addr_ctr #(.AW(AW)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .capture   (capture),
        .step      (step),
        .stop_addr (stop_addr),
        .xfer_len  (xfer_len),
        .rd_addr   (rd_addr),
        .last_word (last_word)
    );

    rrd_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_n     (clr_n),
        .eor       (eor),
        .dma_ack   (dma_ack),
        .tick      (tick),
        .last_word (last_word),
        .dma_req   (dma_req),
        .acq_oe    (acq_oe),
        .done      (done),
        .fetch_win (fetch_win),
        .load      (load),
        .capture   (capture),
        .step      (step)
    );

    // The acknowledge itself opens the host-side latch
    assign bus_oe   = dma_ack && fetch_win;
    assign data_out = bus_oe ? {ch1_byte, ch2_byte} : WW'(0);

    // R4: a request that is being acknowledged must drive the host bus
    a_r4_ack_opens_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && dma_ack) |-> bus_oe);

    // R3: no host bus drive while the acquisition side owns the samples
    a_r3_no_double_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_oe && acq_oe));

endmodule

// File: tb/rec_readout_dma_tb.sv
module rec_readout_dma_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = CLK_PERIOD / 4;
    localparam int AW         = 12;
    localparam int DEPTH      = 4096;
    localparam int PDIV       = 5;

    logic        clk;
    logic        rst_n;
    logic        clr_n;
    logic        eor;
    logic [11:0] stop_addr;
    logic [12:0] xfer_len;
    logic        dma_ack;
    logic [7:0]  ch1_byte;
    logic [7:0]  ch2_byte;
    logic        dma_req;
    logic        bus_oe;
    logic        acq_oe;
    logic        done;
    logic [11:0] rd_addr;
    logic [15:0] data_out;

    int checks = 0;
    int errors = 0;

    rec_readout_dma #(.AW(AW), .BW(8), .PACE_DIV(PDIV)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_n     (clr_n),
        .eor       (eor),
        .stop_addr (stop_addr),
        .xfer_len  (xfer_len),
        .dma_ack   (dma_ack),
        .ch1_byte  (ch1_byte),
        .ch2_byte  (ch2_byte),
        .dma_req   (dma_req),
        .bus_oe    (bus_oe),
        .acq_oe    (acq_oe),
        .done      (done),
        .rd_addr   (rd_addr),
        .data_out  (data_out)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    // sample memory contents as a function of address
    function automatic logic [7:0] mem1(logic [11:0] a);
        return a[7:0] ^ 8'hA5;
    endfunction
    function automatic logic [7:0] mem2(logic [11:0] a);
        return {a[11:8], a[3:0]} ^ 8'h3C;
    endfunction

    assign ch1_byte = mem1(rd_addr);
    assign ch2_byte = mem2(rd_addr);

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // host acknowledge responder
    logic ack_auto;
    logic ack_man;
    bit   auto_on = 1'b0;
    int   ack_wait = 0;
    int   ack_hold = 0;
    int   acks_done = 0;
    int   wcnt = 0;
    int   hcnt = 0;

    assign dma_ack = auto_on ? ack_auto : ack_man;

    initial ack_auto = 1'b0;
    always @(negedge clk) begin
        if (!rst_n) begin
            ack_auto = 1'b0;
            wcnt = 0;
            hcnt = 0;
        end else if (ack_auto) begin
            if (hcnt >= ack_hold) begin
                ack_auto = 1'b0;
                acks_done++;
            end else begin
                hcnt++;
            end
        end else if (dma_req && auto_on) begin
            if (wcnt >= ack_wait) begin
                ack_auto = 1'b1;
                hcnt = 0;
                wcnt = 0;
            end else begin
                wcnt++;
            end
        end
    end

    // behavioural reference: 0 idle, 1 asking, 2 ack held, 3 waiting tick, 4 finished
    int m_st = 0;
    int m_addr = 0;
    int m_cnt = 0;
    int m_len = 0;
    int m_pc = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_addr = 0; m_cnt = 0; m_len = 0; m_pc = 0;
        end else begin
            automatic bit tk = (m_pc == PDIV - 1);
            automatic int prev = m_st;
            m_pc = (m_pc + 1) % PDIV;
            if (prev == 0) begin
                m_addr = int'(stop_addr);
                m_cnt = 0;
                if (eor) m_len = int'(xfer_len);
            end
            if (!clr_n) begin
                m_st = 0;
            end else begin
                case (prev)
                    0: if (eor) m_st = 1;
                    1: if (dma_ack) m_st = 2;
                    2: if (!dma_ack) begin
                        m_addr = (m_addr + 1) % DEPTH;
                        if (m_cnt == m_len - 1) m_st = 4;
                        else begin m_cnt++; m_st = 3; end
                    end
                    3: if (tk) m_st = 1;
                    default: ;
                endcase
            end
        end
    end

    // per-cycle comparison, a quarter period after the falling edge
    always @(negedge clk) begin
        #Q;
        if (rst_n) begin
            automatic bit e_oe = dma_ack && (m_st == 1 || m_st == 2);
            automatic logic [15:0] e_data = e_oe ? {mem1(12'(m_addr)), mem2(12'(m_addr))} : 16'h0;
            chk(dma_req == (m_st == 1), "R7 request/pace", dma_req, m_st == 1);
            chk(acq_oe == (m_st == 0), "R3 acq_oe", acq_oe, m_st == 0);
            chk(done == (m_st == 4), "R8 done", done, m_st == 4);
            chk(int'(rd_addr) == m_addr, "R6 rd_addr", rd_addr, m_addr);
            chk(bus_oe == e_oe, "R4 bus_oe", bus_oe, e_oe);
            chk(data_out == e_data, "R5 data_out", data_out, e_data);
        end
    end

    task automatic run_record(input int stop, input int len, input int w, input int h);
        int base;
        int guard;
        ack_wait = w;
        ack_hold = h;
        stop_addr = 12'(stop);
        xfer_len = 13'(len);
        @(negedge clk);
        @(negedge clk);
        base = acks_done;
        eor = 1'b1;
        @(negedge clk);
        eor = 1'b0;
        #Q;
        chk(dma_req == 1'b1, "R2 request after eor", dma_req, 1);
        chk(rd_addr == 12'(stop), "R2 first address", rd_addr, stop);
        guard = 0;
        while (!done && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        chk(done == 1'b1, "R8 finished", done, 1);
        chk(acks_done - base == len, "R8 word count", acks_done - base, len);
        chk(rd_addr == 12'((stop + len) % DEPTH), "R6 wrap end address", rd_addr, (stop + len) % DEPTH);
        @(negedge clk);
        eor = 1'b1;
        @(negedge clk);
        eor = 1'b0;
        #Q;
        chk(done && !dma_req, "R10 eor ignored in done", {done, dma_req}, 2'b10);
        @(negedge clk);
        clr_n = 1'b0;
        @(negedge clk);
        clr_n = 1'b1;
        #Q;
        chk(!done && acq_oe, "R9 clear to idle", {done, acq_oe}, 2'b01);
    endtask

    initial begin
        int base;
        int guard;
        rst_n = 1'b0;
        clr_n = 1'b1;
        eor = 1'b0;
        stop_addr = '0;
        xfer_len = 13'd1;
        ack_man = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #Q;
        chk(!dma_req && !done && acq_oe && !bus_oe && rd_addr == 12'd0,
            "R1 reset state", {dma_req, done, acq_oe, bus_oe}, 4'b0010);

        // stray acknowledge while idle
        @(negedge clk);
        ack_man = 1'b1;
        @(negedge clk);
        #Q;
        chk(bus_oe == 1'b0 && data_out == 16'h0, "R4 ack ignored in idle", bus_oe, 0);
        @(negedge clk);
        ack_man = 1'b0;
        auto_on = 1'b1;

        run_record(100, 5, 0, 0);
        run_record(4094, 6, 2, 3);
        run_record(7, 1, 1, 0);
        run_record(4095, 3, 0, 1);

        // abort while an acknowledge is held
        ack_wait = 1;
        ack_hold = 4;
        stop_addr = 12'd50;
        xfer_len = 13'd10;
        @(negedge clk);
        @(negedge clk);
        base = acks_done;
        eor = 1'b1;
        @(negedge clk);
        eor = 1'b0;
        guard = 0;
        while (!(acks_done - base >= 2 && ack_auto) && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        clr_n = 1'b0;
        @(negedge clk);
        clr_n = 1'b1;
        #Q;
        chk(acq_oe && !dma_req && !done, "R9 abort mid-handshake", {acq_oe, dma_req, done}, 3'b100);
        chk(bus_oe == 1'b0, "R4 stale ack after abort", bus_oe, 0);
        repeat (6) @(negedge clk);

        run_record(300, 4, 1, 1);

        repeat (4) @(negedge clk);
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

endmodule